// File: doc/BRIEF.md
# PCI-to-ISA interrupt router

This block maps the four level-sensitive PCI interrupt pins (A, B, C, D) of a bridge onto a sixteen-line ISA interrupt bus. Software programs a 4-bit target for each pin by writing config bytes through a byte-wide write port. A target of zero parks the pin, and any nonzero target names the ISA line that the pin drives. When several pins share one target, that line carries the OR of their levels.

Three targets (2, 8 and 13) are not legal routing choices on an ISA bus. The block still routes a pin that points at one of them. It also latches a sticky error flag, which software clears with a dedicated input. The ISA lines are computed combinationally from the stored routing bytes and the live pin levels. A rewrite of a routing field therefore moves an interrupt that is already asserted, with no drain step.

Top module: `pirq_isa_router`

## Requirements
- R1: Pin A (pirq_i bit 0) takes its target from config byte 0x55 bits [7:4]; bits [3:0] of that byte have no effect on routing.
- R2: Pin B (pirq_i bit 1) takes its target from config byte 0x56 bits [3:0], and pin C (pirq_i bit 2) takes its target from byte 0x56 bits [7:4].
- R3: Pin D (pirq_i bit 3) takes its target from config byte 0x57 bits [7:4]; bits [3:0] of that byte have no effect.
- R4: A config write stores cfg_data_i at the rising clock edge where cfg_we_i is high. Writes to any address other than 0x55, 0x56 and 0x57 change no routing.
- R5: A target of 0 disables the pin. ISA line 0 (isa_irq_o bit 0) is never driven.
- R6: Each bit n of isa_irq_o is the OR of all pins that are high and whose target equals n.
- R7: isa_irq_o follows pirq_i combinationally. A routing write moves an asserted interrupt to its new line right after the write edge.
- R8: A pin routed to target 2, 8 or 13 still drives that line. If such a pin is high at a rising edge, rsvd_err_o is 1 after that edge.
- R9: rsvd_err_o holds until err_clr_i is high at an edge where no reserved hit is present. If a hit and a clear arrive at the same edge, the hit wins.
- R10: After reset all routing bytes are zero, so isa_irq_o is 0 for any pin levels, and rsvd_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config byte write strobe |
| cfg_addr_i | input | 8 | Config byte address |
| cfg_data_i | input | 8 | Config byte write data |
| pirq_i | input | 4 | PCI interrupt levels, bit 0 = A to bit 3 = D |
| err_clr_i | input | 1 | Clear for the reserved-target flag |
| isa_irq_o | output | 16 | ISA interrupt line levels |
| rsvd_err_o | output | 1 | Sticky reserved-target error flag |

## Verification
Two functions can meet at the same clock edge: a new reserved-target hit that sets the error flag, and a software clear of that flag. The bench holds pin A high on target 8 while it drives err_clr_i high. It then expects the flag to stay set after that edge. Next it drops the pin while the clear is still high, and it expects the flag to fall. This shows that a clear loses only while a hit is present.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  localparam int unsigned PIN_CNT   = 4;
  localparam int unsigned LINE_CNT  = 16;
  localparam int unsigned FIELD_W   = $clog2(LINE_CNT);
  localparam int unsigned CFG_BYTES = 3;
  localparam int unsigned BYTE_IDX_W = $clog2(CFG_BYTES);

  // per pin: which routing byte (offset from base) and which nibble
  localparam int unsigned PIN_BYTE [PIN_CNT] = '{0, 1, 1, 2};
  localparam bit          PIN_HI   [PIN_CNT] = '{1'b1, 1'b0, 1'b1, 1'b1};

  localparam logic [LINE_CNT-1:0] RSVD_MASK_DEF = 16'h2104; // lines 13, 8, 2

  typedef logic [CFG_BYTES-1:0][7:0]       cfg_bytes_t;
  typedef logic [PIN_CNT-1:0][FIELD_W-1:0] route_t;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_route_pkg::*;
#(
  parameter logic [7:0] CFG_BASE = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  output cfg_bytes_t cfg_o
);
  cfg_bytes_t cfg_q;

  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
    localparam logic [7:0] ADDR = 8'(CFG_BASE + 8'(b));
    logic sel;
    assign sel = we_i && (addr_i == ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_q[b] <= '0;
      else if (sel) cfg_q[b] <= data_i;
    end

    // R4: addressed byte takes the written data
    a_r4_byte_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR) |=> (cfg_o[b] == $past(data_i)));
    // R4: unaddressed byte holds
    a_r4_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR) |=> $stable(cfg_o[b]));
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pirq_field_sel.sv
module pirq_field_sel
  import pirq_route_pkg::*;
(
  input  cfg_bytes_t cfg_i,
  output route_t     route_o
);
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    if (PIN_HI[p]) begin : g_hi
      assign route_o[p] = cfg_i[PIN_BYTE[p]][7:4];
    end else begin : g_lo
      assign route_o[p] = cfg_i[PIN_BYTE[p]][3:0];
    end
  end
endmodule

// File: rtl/pirq_line_map.sv
module pirq_line_map
  import pirq_route_pkg::*;
#(
  parameter logic [LINE_CNT-1:0] RSVD_MASK = RSVD_MASK_DEF
) (
  input  route_t              route_i,
  input  logic [PIN_CNT-1:0]  pirq_i,
  output logic [LINE_CNT-1:0] lines_o,
  output logic                rsvd_hit_o
);
  logic [PIN_CNT-1:0][LINE_CNT-1:0] pin_vec;

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_dec
    always_comb begin
      pin_vec[p] = '0;
      if (pirq_i[p] && (route_i[p] != '0)) pin_vec[p][route_i[p]] = 1'b1;
    end
  end

  always_comb begin
    lines_o = '0;
    for (int p = 0; p < PIN_CNT; p++) lines_o |= pin_vec[p];
  end

  assign rsvd_hit_o = |(lines_o & RSVD_MASK);
endmodule

// File: rtl/pirq_isa_router.sv
module pirq_isa_router
  import pirq_route_pkg::*;
#(
  parameter logic [7:0]          CFG_BASE  = 8'h55,
  parameter logic [LINE_CNT-1:0] RSVD_MASK = RSVD_MASK_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [7:0]          cfg_addr_i,
  input  logic [7:0]          cfg_data_i,
  input  logic [PIN_CNT-1:0]  pirq_i,
  input  logic                err_clr_i,
  output logic [LINE_CNT-1:0] isa_irq_o,
  output logic                rsvd_err_o
);
  cfg_bytes_t cfg;
  route_t     route;
  logic       rsvd_hit;
  logic       err_q;

  pirq_cfg_regs #(.CFG_BASE(CFG_BASE)) u_regs (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .addr_i(cfg_addr_i), .data_i(cfg_data_i), .cfg_o(cfg)
  );

  pirq_field_sel u_sel (.cfg_i(cfg), .route_o(route));

  pirq_line_map #(.RSVD_MASK(RSVD_MASK)) u_map (
    .route_i(route), .pirq_i(pirq_i), .lines_o(isa_irq_o), .rsvd_hit_o(rsvd_hit)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (rsvd_hit)  err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end
  assign rsvd_err_o = err_q;

  a_r5_line0_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isa_irq_o[0]);

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_chk
    // R6: a live, enabled pin shows on its target line
    a_r6_pin_reaches_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pirq_i[p] && route[p] != '0) |-> isa_irq_o[route[p]]);
  end

  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_hit |=> rsvd_err_o);
  a_r9_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsvd_err_o && !err_clr_i) |=> rsvd_err_o);
  a_r9_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !rsvd_hit) |=> !rsvd_err_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsvd_err_o && !rsvd_hit) |=> !rsvd_err_o);
endmodule

// File: tb/sim_pirq_isa_router.sv
module sim_pirq_isa_router;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {byte55, byte56, byte57, pirq[3:0], exp_isa[15:0], exp_err}
  localparam logic [44:0] VEC [NVEC] = '{
    {8'h50, 8'h00, 8'h00, 4'b0001, 16'h0020, 1'b0},
    {8'h50, 8'hA9, 8'hB0, 4'b1111, 16'h0E20, 1'b0},
    {8'h50, 8'hA9, 8'hB0, 4'b0110, 16'h0600, 1'b0},
    {8'hA0, 8'hAA, 8'hA0, 4'b1111, 16'h0400, 1'b0},
    {8'hA0, 8'hAA, 8'hA0, 4'b0001, 16'h0400, 1'b0},
    {8'h00, 8'h30, 8'h00, 4'b1111, 16'h0008, 1'b0},
    {8'h20, 8'h8D, 8'hF0, 4'b1111, 16'hA104, 1'b1},
    {8'h20, 8'h8D, 8'hF0, 4'b1000, 16'h8000, 1'b0},
    {8'h5F, 8'h0F, 8'hF7, 4'b1111, 16'h8020, 1'b0},
    {8'h20, 8'h00, 8'h00, 4'b0000, 16'h0000, 1'b0}
  };

  logic        clk = 0, rst_n = 0, we = 0, clr = 0;
  logic [7:0]  addr = 0, data = 0;
  logic [3:0]  pirq = 0;
  logic [15:0] isa;
  logic        err;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_isa_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_data_i(data), .pirq_i(pirq), .err_clr_i(clr),
    .isa_irq_o(isa), .rsvd_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1; addr = a; data = d;
    @(negedge clk);
    we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    pirq = 4'hF; #1;
    chk("R10 isa after reset", 32'(isa), 0);
    chk("R10 err after reset", 32'(err), 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R10 isa with zero routing", 32'(isa), 0);

    // vector table: R1 R2 R3 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      pirq = 0; clr = 1;
      @(negedge clk);
      clr = 0;
      wr(8'h55, VEC[i][44:37]);
      wr(8'h56, VEC[i][36:29]);
      wr(8'h57, VEC[i][28:21]);
      pirq = VEC[i][20:17];
      @(negedge clk); #1;
      chk($sformatf("R6 R1 R2 R3 vector %0d isa", i), 32'(isa), 32'(VEC[i][16:1]));
      chk($sformatf("R8 vector %0d err", i), 32'(err), 32'(VEC[i][0]));
    end

    // R4: other addresses ignored
    pirq = 0; clr = 1; @(negedge clk); clr = 0;
    wr(8'h55, 8'h50); wr(8'h56, 8'h00); wr(8'h57, 8'h00);
    pirq = 4'b1111;
    wr(8'h54, 8'hFF); wr(8'h58, 8'hFF); wr(8'hD5, 8'hFF); #1;
    chk("R4 stray addresses", 32'(isa), 32'h0020);

    // R7: combinational follow of pins and of routing
    pirq = 4'b0000; #1;
    chk("R7 pin drop immediate", 32'(isa), 0);
    pirq = 4'b0001; #1;
    chk("R7 pin rise immediate", 32'(isa), 32'h0020);
    wr(8'h55, 8'h70); #1;
    chk("R7 reroute moves irq", 32'(isa), 32'h0080);

    // R9: sticky, then clear, then set-beats-clear
    wr(8'h55, 8'h20);
    @(negedge clk); #1;
    chk("R8 reserved hit sets flag", 32'(err), 1);
    chk("R8 reserved line still driven", 32'(isa), 32'h0004);
    pirq = 0;
    repeat (3) @(negedge clk);
    #1 chk("R9 flag sticky", 32'(err), 1);
    clr = 1; @(negedge clk); clr = 0; #1;
    chk("R9 clear drops flag", 32'(err), 0);
    wr(8'h55, 8'h80);
    pirq = 4'b0001; clr = 1;
    @(negedge clk); #1;
    chk("R9 hit beats clear", 32'(err), 1);
    pirq = 0;
    @(negedge clk); #1;
    chk("R9 clear after hit gone", 32'(err), 0);
    clr = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule